// File: doc/BRIEF.md
# Data-Ready Flag Timer for a Dual-Integrator Converter

This block produces the active-low data-ready flag of a dual-integrator current-input converter. A slow timing enable, one pulse every six system clocks, paces all of its counting. Each accepted edge of the integration-control input `conv` starts a run, and the flag falls a fixed number of system clocks later. The flag then stays low until the reader pulls its transfer strobe `xmit_n` low.

The sequencer tells the block at each accepted edge which mode applies. In the phase-aligned (continuous) mode, the slow divider is restarted at phase zero on the edge. It is frozen again once the run's flag has been issued, so the latency has no jitter. In the free-running (non-continuous) mode the divider is never frozen. The first flag then lands within a few clocks of nominal, depending on the divider phase. A second flag is then chained from the first, counted in whole slow ticks, so the spacing between the two flags has no jitter.

Top module: `dready_gen`

## Requirements
- R1: After reset `dvalid_n` is 1 and the block is idle. The level of `conv` during reset counts as no edge, so `dvalid_n` stays 1 until `conv` changes.
- R2: Phase-aligned mode: number the rising clock edge that first samples a changed `conv` as edge 0. `dvalid_n` is then 0 right after edge 4212, exactly, whatever the earlier divider phase was.
- R3: Free-running mode: the first fall of `dvalid_n` comes after an edge between 4209 and 4215 inclusive, counted from edge 0. The exact value depends on the free-running divider phase, so different phases give different latencies.
- R4: Free-running mode: a second fall of `dvalid_n` comes exactly 4548 edges after the first, with `dvalid_n` still 1 one edge earlier if the reader cleared the first flag.
- R5: Phase-aligned mode issues exactly one flag per accepted `conv` edge: no second flag follows.
- R6: Once low, `dvalid_n` stays 0 until an edge samples `xmit_n` = 0. It is 1 right after that edge.
- R7: When `xmit_n` = 0 is sampled on the same edge where a new flag is due, the new flag wins and `dvalid_n` is 0 after that edge.
- R8: A change of `conv` that arrives while a run is still counting (before its last flag) is ignored and does not move any flag.
- R9: The slow tick pulses at most once in any six consecutive clocks. It does not pulse while the divider is frozen after a phase-aligned run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv | input | 1 | Integration-control level; every change ends an integration |
| seq_cont | input | 1 | Sequencer mode, sampled on an accepted edge: 1 phase-aligned, 0 free-running |
| xmit_n | input | 1 | Active-low read strobe that clears the flag |
| dvalid_n | output | 1 | Active-low data-ready flag |

## Verification
The reader's clearing strobe and the chained second data-ready of the free-running mode can fall on the same clock edge. The bench first clears the first flag early. It then drives `xmit_n` low so that it is sampled exactly on the edge 4548 clocks after the first flag. It expects the flag to stay high one edge before and to be low after that edge, so setting must beat clearing. The other runs use the same edge count without the strobe. Together they show that the chained spacing is exact for every divider phase swept.

// File: rtl/dready_pkg.sv
package dready_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_FIRST = 2'd1,
        TMR_CHAIN = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic first_fire;
        logic chain_fire;
        logic busy;
        logic stop_div;
    } tmr_out_t;

    // Tick target of the first flag. A free-running divider whose next phase
    // lies in the upper half skips one extra tick, which centres the jitter.
    function automatic int first_target(input logic cont, input int phase,
                                        input int half, input int base);
        if (cont) return base;
        return (phase >= half) ? base + 1 : base;
    endfunction

endpackage

// File: rtl/dready_edge.sv
module dready_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic toggled
);
    logic level_q;

    always_ff @(posedge clk) begin
        level_q <= level;
    end

    assign toggled = !rst && (level != level_q);
endmodule

// File: rtl/dready_div.sv
module dready_div #(
    parameter int DIV = 6,
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          freeze,
    input  logic          restart,
    output logic          tick,
    output logic [DW-1:0] phase_nxt
);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] phase_q;

    assign tick = !freeze && !rst && (phase_q == LAST);

    always_comb begin
        if (restart)
            phase_nxt = '0;
        else if (freeze)
            phase_nxt = phase_q;
        else if (phase_q == LAST)
            phase_nxt = '0;
        else
            phase_nxt = phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else
            phase_q <= phase_nxt;
    end
endmodule

// File: rtl/dready_timer.sv
module dready_timer
    import dready_pkg::*;
#(
    parameter int DIV        = 6,
    parameter int FIRST_LAT  = 4212,
    parameter int SECOND_LAT = 4548,
    localparam int DW        = (DIV > 1) ? $clog2(DIV) : 1,
    localparam int T1        = FIRST_LAT / DIV,
    localparam int T2        = SECOND_LAT / DIV,
    localparam int TMAX      = (T1 + 1 > T2) ? T1 + 1 : T2,
    localparam int CW        = $clog2(TMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cont,
    input  logic          tick,
    input  logic [DW-1:0] phase_nxt,
    output tmr_out_t      out
);
    tmr_state_e    state_q;
    logic [CW-1:0] ticks_q;
    logic [CW-1:0] target_q;
    logic          cont_q;
    logic          last_tick;

    assign last_tick = tick && (ticks_q == target_q - 1'b1);

    always_comb begin
        out.first_fire = (state_q == TMR_FIRST) && last_tick;
        out.chain_fire = (state_q == TMR_CHAIN) && last_tick;
        out.busy       = (state_q != TMR_IDLE);
        out.stop_div   = out.first_fire && cont_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= TMR_IDLE;
            ticks_q  <= '0;
            target_q <= CW'(T1);
            cont_q   <= 1'b0;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    if (start) begin
                        state_q  <= TMR_FIRST;
                        ticks_q  <= '0;
                        cont_q   <= cont;
                        target_q <= CW'(first_target(cont, int'(phase_nxt),
                                                     DIV / 2, T1));
                    end
                end
                TMR_FIRST: begin
                    if (last_tick) begin
                        ticks_q  <= '0;
                        target_q <= CW'(T2);
                        state_q  <= cont_q ? TMR_IDLE : TMR_CHAIN;
                    end else if (tick) begin
                        ticks_q <= ticks_q + 1'b1;
                    end
                end
                TMR_CHAIN: begin
                    if (last_tick) begin
                        ticks_q <= '0;
                        state_q <= TMR_IDLE;
                    end else if (tick) begin
                        ticks_q <= ticks_q + 1'b1;
                    end
                end
                default: state_q <= TMR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dready_gen.sv
module dready_gen
    import dready_pkg::*;
#(
    parameter int DIV        = 6,
    parameter int FIRST_LAT  = 4212,
    parameter int SECOND_LAT = 4548,
    localparam int DW        = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic conv,
    input  logic seq_cont,
    input  logic xmit_n,
    output logic dvalid_n
);
    logic          conv_edge;
    logic          accept;
    logic          restart;
    logic          frozen_q;
    logic          slow_tick;
    logic [DW-1:0] phase_nxt;
    logic          fire_any;
    tmr_out_t      tmr;

    dready_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .level  (conv),
        .toggled(conv_edge)
    );

    assign accept  = conv_edge && !tmr.busy;
    assign restart = accept && seq_cont;

    dready_div #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .freeze   (frozen_q),
        .restart  (restart),
        .tick     (slow_tick),
        .phase_nxt(phase_nxt)
    );

    dready_timer #(
        .DIV       (DIV),
        .FIRST_LAT (FIRST_LAT),
        .SECOND_LAT(SECOND_LAT)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .cont     (seq_cont),
        .tick     (slow_tick),
        .phase_nxt(phase_nxt),
        .out      (tmr)
    );

    assign fire_any = tmr.first_fire || tmr.chain_fire;

    always_ff @(posedge clk) begin
        if (rst)
            frozen_q <= 1'b0;
        else if (accept)
            frozen_q <= 1'b0;
        else if (tmr.stop_div)
            frozen_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dvalid_n <= 1'b1;
        else if (fire_any)
            dvalid_n <= 1'b0;
        else if (!xmit_n)
            dvalid_n <= 1'b1;
    end
endmodule

// File: rtl/dready_chk.sv
module dready_chk (
    input logic clk,
    input logic rst,
    input logic xmit_n,
    input logic dvalid_n,
    input logic fire_any,
    input logic slow_tick,
    input logic frozen_q,
    input logic restart
);
    // R7
    fire_sets_chk: assert property (@(posedge clk) disable iff (rst)
        fire_any |=> !dvalid_n);

    // R6
    strobe_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!xmit_n && !fire_any) |=> dvalid_n);

    // R6
    flag_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!dvalid_n && xmit_n) |=> !dvalid_n);

    // R8
    no_stray_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (dvalid_n && !fire_any) |=> dvalid_n);

    // R9
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        slow_tick |=> !slow_tick);

    // R9
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && !restart) |-> !slow_tick);
endmodule

bind dready_gen dready_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .xmit_n   (xmit_n),
    .dvalid_n (dvalid_n),
    .fire_any (fire_any),
    .slow_tick(slow_tick),
    .frozen_q (frozen_q),
    .restart  (restart)
);

// File: tb/tb_dready_gen.sv
module tb_dready_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv = 1'b0;
    logic seq_cont = 1'b0;
    logic xmit_n = 1'b1;
    logic dvalid_n;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;

    dready_gen dut (
        .clk     (clk),
        .rst     (rst),
        .conv    (conv),
        .seq_cont(seq_cont),
        .xmit_n  (xmit_n),
        .dvalid_n(dvalid_n)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic strobe();
        xmit_n = 1'b0;
        @(negedge clk);
        xmit_n = 1'b1;
    endtask

    task automatic wait_low();
        while (dvalid_n) @(negedge clk);
    endtask

    initial begin
        wait (cyc == 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t0, e1, lat, lmin, lmax;
        lmin = 99999;
        lmax = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset flag", int'(dvalid_n), 1);
        repeat (100) @(negedge clk);
        check("R1 no edge from reset level", int'(dvalid_n), 1);

        // free-running sweep over six divider phases
        for (int i = 0; i < 6; i++) begin
            repeat (7 * i + 1) @(negedge clk);
            conv = ~conv;
            t0 = cyc + 1;
            repeat (1000) @(negedge clk);
            conv = ~conv;            // R8: ignored while busy
            wait_low();
            e1 = cyc;
            lat = e1 - t0;
            if (lat < lmin) lmin = lat;
            if (lat > lmax) lmax = lat;
            total++;
            if (lat < 4209 || lat > 4215) begin
                bad++;
                $display("FAIL R3/R8 latency actual=%0d expected=4209..4215", lat);
            end
            wait_cyc(e1 + 9);
            check("R6 flag held before strobe", int'(dvalid_n), 0);
            strobe();
            check("R6 cleared by strobe", int'(dvalid_n), 1);
            wait_cyc(e1 + 4547);
            check("R4 high one edge before chain", int'(dvalid_n), 1);
            if (i == 0) begin
                strobe();
                check("R7 set beats strobe", int'(dvalid_n), 0);
            end else begin
                @(negedge clk);
                check("R4 chained flag spacing", int'(dvalid_n), 0);
            end
            repeat (3) @(negedge clk);
            strobe();
            check("R6 chained flag cleared", int'(dvalid_n), 1);
        end
        total++;
        if (lmax == lmin) begin
            bad++;
            $display("FAIL R3 phase spread actual=%0d expected>0", lmax - lmin);
        end

        // phase-aligned runs
        seq_cont = 1'b1;
        for (int k = 0; k < 3; k++) begin
            repeat (5 * k + 3) @(negedge clk);
            conv = ~conv;
            t0 = cyc + 1;
            if (k == 1) begin
                repeat (2000) @(negedge clk);
                conv = ~conv;        // R8: ignored while busy
            end
            wait_low();
            check("R2 aligned latency", cyc - t0, 4212);
            strobe();
            check("R6 aligned cleared", int'(dvalid_n), 1);
            if (k == 0) begin
                repeat (4700) @(negedge clk);
                check("R5 no chained flag", int'(dvalid_n), 1);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule